// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between a processor's load/store stage and a word-wide data memory. On the request side it forms the effective byte address as a base value plus a sign-extended 16-bit displacement. It drops the two low address bits to get the memory word address. It then works out which byte lanes of the word the access touches, counting byte offset 0 as the most significant lane. Store data is moved into the selected lanes. Accesses that break the alignment rule for their size are flagged and not issued.

On the response side, the core returns the 32-bit word read from memory along with the byte offset, size and signedness of the original load. The block picks out the addressed byte or halfword, extends it to 32 bits with the sign or with zeros, and presents the result. Both paths are fully registered and each result appears one clock after its inputs.

Top module: `be_lsu_align`

## Requirements
- R1: The effective address is `base_addr + sign_extend(req_offset)`, with offsets from -32768 to +32767. `mem_word_addr` equals the effective address with its two low bits removed. It appears one cycle after an accepted request, whether that request is a store (`req_write`=1) or a load (`req_write`=0), and `mem_write` copies `req_write` for aligned requests.
- R2: A byte request (size code 0) at byte offset k (0..3) sets only `mem_be` bit 3-k and never misaligns. `mem_wdata` carries the low store byte replicated into all four lanes, so lane k holds it in bits [31-8k:24-8k].
- R3: A halfword request (size code 1) at offset 0 gives `mem_be`=1100. At offset 2 it gives `mem_be`=0011. `mem_wdata` is the low 16 store bits repeated in both halves.
- R4: A word request (size code 2) at offset 0 gives `mem_be`=1111 and `mem_wdata` equal to the store data.
- R5: A halfword at an odd address, a word at a non-multiple of 4, or size code 3 sets `misalign` for one cycle, with `mem_valid`=0, `mem_write`=0 and `mem_be`=0000.
- R6: A signed byte load (`rsp_unsigned`=0, size 0) at offset k returns `rsp_word` bits [31-8k:24-8k] with bit 7 of that byte copied into result bits 31..8.
- R7: An unsigned byte or halfword load fills every result bit above the loaded value with zeros.
- R8: A halfword load takes `rsp_word[31:16]` when offset bit 1 is 0 and `rsp_word[15:0]` when it is 1. Offset bit 0 is ignored. A signed halfword load copies bit 15 into bits 31..16.
- R9: A load with size code 2 or 3 returns `rsp_word` unchanged, whatever the offset and signedness.
- R10: While `rst` is high, on each clock `mem_valid`, `mem_write`, `misalign`, `mem_be` and `load_valid` are all cleared.
- R11: A cycle with `req_valid`=0 gives `mem_valid`=0 and `misalign`=0 on the next cycle. A cycle with `rsp_valid`=0 gives `load_valid`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| base_addr | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_valid | output | 1 | Aligned access issued to memory |
| mem_write | output | 1 | Issued access is a write |
| mem_word_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte enables, bit 3 = lowest byte address |
| mem_wdata | output | 32 | Lane-placed write data |
| misalign | output | 1 | Request broke alignment and was dropped |
| rsp_valid | input | 1 | Returned read word present |
| rsp_word | input | 32 | Word read from memory |
| rsp_lane | input | 2 | Byte offset of the load |
| rsp_size | input | 2 | Size code of the load |
| rsp_unsigned | input | 1 | 1 = zero-extend, 0 = sign-extend |
| load_valid | output | 1 | Load result present |
| load_data | output | 32 | Extracted and extended load value |

## Verification
Every request output and every load result is registered once, so each result is due on the clock edge right after the edge that samples its stimulus. The driver tags each expected item with the cycle number it is due in. The monitor pops an item only once the cycle counter reaches that number and compares it at the falling edge, when the registered outputs are stable. Write data is compared only for issued accesses, and the word address only for cycles with a request.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

endpackage

// File: rtl/lsu_ea_check.sv
module lsu_ea_check
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] ea,
  output logic              mis
);

  localparam int EXT_W = ADDR_W - OFF_W;

  assign ea = base + {{EXT_W{offset[OFF_W-1]}}, offset};

  always_comb begin
    unique case (size)
      SZ_BYTE: mis = 1'b0;
      SZ_HALF: mis = ea[0];
      SZ_WORD: mis = |ea[LANE_W-1:0];
      default: mis = 1'b1;
    endcase
  end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  acc_size_e                   size,
  input  logic [DATA_W-1:0]           wd_in,
  output logic [DATA_W/8-1:0]         be,
  output logic [DATA_W-1:0]           wd_out
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // byte-enable bit i covers byte offset K (big-endian numbering)
    localparam int K     = LANES - 1 - i;
    localparam bit UPPER = (K % 2) == 0;
    logic       lane_en;
    logic [7:0] lane_d;

    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          lane_en = (lane == LANE_W'(K));
          lane_d  = wd_in[7:0];
        end
        SZ_HALF: begin
          lane_en = (lane[LANE_W-1:1] == (LANE_W-1)'(K / 2));
          lane_d  = UPPER ? wd_in[15:8] : wd_in[7:0];
        end
        SZ_WORD: begin
          lane_en = 1'b1;
          lane_d  = wd_in[8*i +: 8];
        end
        default: begin
          lane_en = 1'b0;
          lane_d  = wd_in[8*i +: 8];
        end
      endcase
    end

    assign be[i]            = lane_en;
    assign wd_out[8*i +: 8] = lane_d;
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           word,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  acc_size_e                   size,
  input  logic                        uns,
  output logic [DATA_W-1:0]           data
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int HALVES = LANES / 2;

  logic [7:0]  byte_v;
  logic [15:0] half_v;

  always_comb begin
    byte_v = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane == LANE_W'(k)) byte_v = word[DATA_W-1-8*k -: 8];
    end
  end

  always_comb begin
    half_v = '0;
    for (int h = 0; h < HALVES; h++) begin
      if (lane[LANE_W-1:1] == (LANE_W-1)'(h)) half_v = word[DATA_W-1-16*h -: 16];
    end
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: data = {{(DATA_W-8){~uns & byte_v[7]}}, byte_v};
      SZ_HALF: data = {{(DATA_W-16){~uns & half_v[15]}}, half_v};
      default: data = word;
    endcase
  end

endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     req_valid,
  input  logic                                     req_write,
  input  logic [1:0]                               req_size,
  input  logic [ADDR_W-1:0]                        base_addr,
  input  logic [OFF_W-1:0]                         req_offset,
  input  logic [DATA_W-1:0]                        req_wdata,
  output logic                                     mem_valid,
  output logic                                     mem_write,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]       mem_word_addr,
  output logic [DATA_W/8-1:0]                      mem_be,
  output logic [DATA_W-1:0]                        mem_wdata,
  output logic                                     misalign,
  input  logic                                     rsp_valid,
  input  logic [DATA_W-1:0]                        rsp_word,
  input  logic [$clog2(DATA_W/8)-1:0]              rsp_lane,
  input  logic [1:0]                               rsp_size,
  input  logic                                     rsp_unsigned,
  output logic                                     load_valid,
  output logic [DATA_W-1:0]                        load_data
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [ADDR_W-1:0] ea_c;
  logic              mis_c;
  logic [LANES-1:0]  be_c;
  logic [DATA_W-1:0] wd_c;
  logic [DATA_W-1:0] ld_c;
  logic              issue_c;

  lsu_ea_check #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .LANE_W(LANE_W)
  ) u_ea (
    .base  (base_addr),
    .offset(req_offset),
    .size  (acc_size_e'(req_size)),
    .ea    (ea_c),
    .mis   (mis_c)
  );

  lsu_store_lanes #(
    .DATA_W(DATA_W)
  ) u_st (
    .lane  (ea_c[LANE_W-1:0]),
    .size  (acc_size_e'(req_size)),
    .wd_in (req_wdata),
    .be    (be_c),
    .wd_out(wd_c)
  );

  lsu_load_extract #(
    .DATA_W(DATA_W)
  ) u_ld (
    .word(rsp_word),
    .lane(rsp_lane),
    .size(acc_size_e'(rsp_size)),
    .uns (rsp_unsigned),
    .data(ld_c)
  );

  assign issue_c = req_valid & ~mis_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid     <= 1'b0;
      mem_write     <= 1'b0;
      misalign      <= 1'b0;
      mem_be        <= '0;
      mem_word_addr <= '0;
      mem_wdata     <= '0;
    end else begin
      mem_valid     <= issue_c;
      mem_write     <= issue_c & req_write;
      misalign      <= req_valid & mis_c;
      mem_be        <= issue_c ? be_c : '0;
      mem_word_addr <= ea_c[ADDR_W-1:LANE_W];
      mem_wdata     <= wd_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_valid <= 1'b0;
      load_data  <= '0;
    end else begin
      load_valid <= rsp_valid;
      if (rsp_valid) load_data <= ld_c;
    end
  end

endmodule

// File: rtl/lsu_align_checker.sv
module lsu_align_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               req_valid,
  input logic [ADDR_W-1:0]                  base_addr,
  input logic [OFF_W-1:0]                   req_offset,
  input logic                               mem_valid,
  input logic                               mem_write,
  input logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_word_addr,
  input logic [DATA_W/8-1:0]                mem_be,
  input logic                               misalign,
  input logic                               rsp_valid,
  input logic [DATA_W-1:0]                  rsp_word,
  input logic [1:0]                         rsp_size,
  input logic                               rsp_unsigned,
  input logic                               load_valid,
  input logic [DATA_W-1:0]                  load_data
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [ADDR_W-1:0] ea_ref;
  assign ea_ref = base_addr + {{(ADDR_W-OFF_W){req_offset[OFF_W-1]}}, req_offset};

  // R10
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!mem_valid && !mem_write && !misalign && mem_be == '0 && !load_valid));

  // R5
  a_r5_misalign_quiet: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (!mem_valid && !mem_write && mem_be == '0));

  // R11
  a_r11_idle_request: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!mem_valid && !misalign));

  // R11
  a_r11_idle_load: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |=> !load_valid);

  // R1
  a_r1_word_addr: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (mem_word_addr == $past(ea_ref[ADDR_W-1:LANE_W])));

  // R2, R3, R4: an issued access enables one, two or all lanes
  a_r4_lane_count: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                   $countones(mem_be) == LANES));

  // R1: writes only with an issued access
  a_r1_write_needs_valid: assert property (@(posedge clk) disable iff (rst)
    mem_write |-> mem_valid);

  // R7
  a_r7_byte_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_unsigned && rsp_size == 2'd0) |=> (load_data[DATA_W-1:8] == '0));

  // R9
  a_r9_word_pass: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_size == 2'd2) |=> (load_data == $past(rsp_word)));

endmodule

bind be_lsu_align lsu_align_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .OFF_W (OFF_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .base_addr    (base_addr),
  .req_offset   (req_offset),
  .mem_valid    (mem_valid),
  .mem_write    (mem_write),
  .mem_word_addr(mem_word_addr),
  .mem_be       (mem_be),
  .misalign     (misalign),
  .rsp_valid    (rsp_valid),
  .rsp_word     (rsp_word),
  .rsp_size     (rsp_size),
  .rsp_unsigned (rsp_unsigned),
  .load_valid   (load_valid),
  .load_data    (load_data)
);

// File: tb/be_lsu_align_test.sv
module be_lsu_align_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [31:0] base_addr;
  logic [15:0] req_offset;
  logic [31:0] req_wdata;
  logic        mem_valid, mem_write, misalign;
  logic [29:0] mem_word_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        rsp_valid, rsp_unsigned;
  logic [31:0] rsp_word;
  logic [1:0]  rsp_lane, rsp_size;
  logic        load_valid;
  logic [31:0] load_data;

  be_lsu_align uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .base_addr(base_addr), .req_offset(req_offset), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_word_addr(mem_word_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .misalign(misalign),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_lane(rsp_lane),
    .rsp_size(rsp_size), .rsp_unsigned(rsp_unsigned),
    .load_valid(load_valid), .load_data(load_data)
  );

  typedef struct {
    int          due;
    bit          v, we, mis, chk_wa, chk_wd;
    logic [29:0] wa;
    logic [3:0]  be;
    logic [31:0] wd;
    string       tag;
  } req_exp_t;

  typedef struct {
    int          due;
    bit          v;
    logic [31:0] d;
    string       tag;
  } ld_exp_t;

  req_exp_t rq[$];
  ld_exp_t  lq[$];
  int errs = 0;
  int checks = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // driver: derive expected results from the current inputs, then advance
  task automatic tick(string rtag, string ltag);
    req_exp_t r;
    ld_exp_t  l;
    logic [31:0] ea;
    logic [1:0]  k;
    logic [7:0]  b;
    logic [15:0] h;
    ea = base_addr + {{16{req_offset[15]}}, req_offset};
    k  = ea[1:0];
    r.due = cyc + 1; r.tag = rtag;
    r.wa = ea[31:2]; r.chk_wa = req_valid;
    r.mis = 1'b0; r.be = 4'b0000; r.wd = '0;
    case (req_size)
      2'd0: begin r.be = 4'b1000 >> k; r.wd = {4{req_wdata[7:0]}}; end
      2'd1: begin r.mis = ea[0]; r.be = k[1] ? 4'b0011 : 4'b1100; r.wd = {2{req_wdata[15:0]}}; end
      2'd2: begin r.mis = (k != 2'd0); r.be = 4'b1111; r.wd = req_wdata; end
      default: r.mis = 1'b1;
    endcase
    if (!req_valid) r.mis = 1'b0;
    r.v  = req_valid && !r.mis;
    r.we = r.v && req_write;
    r.chk_wd = r.v;
    if (!r.v) r.be = 4'b0000;
    rq.push_back(r);

    l.due = cyc + 1; l.tag = ltag; l.v = rsp_valid;
    b = rsp_word[31 - 8*rsp_lane -: 8];
    h = rsp_lane[1] ? rsp_word[15:0] : rsp_word[31:16];
    case (rsp_size)
      2'd0: l.d = rsp_unsigned ? {24'h0, b} : {{24{b[7]}}, b};
      2'd1: l.d = rsp_unsigned ? {16'h0, h} : {{16{h[15]}}, h};
      default: l.d = rsp_word;
    endcase
    lq.push_back(l);
    @(negedge clk);
  endtask

  task automatic req(input logic [1:0] sz, input logic [31:0] base,
                     input logic [15:0] off, input logic [31:0] d,
                     input logic wr, input string tag);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    base_addr = base; req_offset = off; req_wdata = d;
    rsp_valid = 1'b0;
    tick(tag, "R11");
  endtask

  task automatic ld(input logic [31:0] w, input logic [1:0] lane,
                    input logic [1:0] sz, input logic uns, input string tag);
    req_valid = 1'b0;
    rsp_valid = 1'b1; rsp_word = w; rsp_lane = lane;
    rsp_size = sz; rsp_unsigned = uns;
    tick("R11", tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rq.size() > 0 && rq[0].due <= cyc) begin
        req_exp_t e;
        e = rq.pop_front();
        checks++;
        if (mem_valid !== e.v || mem_write !== e.we || misalign !== e.mis ||
            mem_be !== e.be || (e.chk_wa && mem_word_addr !== e.wa) ||
            (e.chk_wd && mem_wdata !== e.wd)) begin
          errs++;
          $display("FAIL %s: req got v=%b we=%b mis=%b be=%b wa=%h wd=%h exp v=%b we=%b mis=%b be=%b wa=%h wd=%h",
                   e.tag, mem_valid, mem_write, misalign, mem_be, mem_word_addr, mem_wdata,
                   e.v, e.we, e.mis, e.be, e.wa, e.wd);
        end
      end
      if (lq.size() > 0 && lq[0].due <= cyc) begin
        ld_exp_t e;
        e = lq.pop_front();
        checks++;
        if (load_valid !== e.v || (e.v && load_data !== e.d)) begin
          errs++;
          $display("FAIL %s: load got v=%b d=%h exp v=%b d=%h",
                   e.tag, load_valid, load_data, e.v, e.d);
        end
      end
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    base_addr = '0; req_offset = '0; req_wdata = '0;
    rsp_valid = 1'b0; rsp_word = '0; rsp_lane = '0; rsp_size = '0; rsp_unsigned = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (mem_valid !== 1'b0 || mem_write !== 1'b0 || misalign !== 1'b0 ||
        mem_be !== 4'b0000 || load_valid !== 1'b0) begin
      errs++;
      $display("FAIL R10: reset got v=%b we=%b mis=%b be=%b lv=%b exp all zero",
               mem_valid, mem_write, misalign, mem_be, load_valid);
    end
    rst = 1'b0;

    // R2: bytes at each offset, big-endian lane order
    for (int k = 0; k < 4; k++) req(2'd0, 32'h0000_1000, 16'(k), 32'h0000_00A5 + 32'(k), 1'b1, "R2");
    // R1: negative and maximum displacements, load request
    req(2'd0, 32'h0000_2000, 16'hFFFD, 32'h0000_0033, 1'b1, "R1");
    req(2'd0, 32'h0000_0000, 16'h7FFF, 32'h0000_0044, 1'b1, "R1");
    req(2'd2, 32'h8000_0010, 16'h8000, 32'h1234_5678, 1'b0, "R1");
    // R3: halfwords
    req(2'd1, 32'h0000_3000, 16'h0000, 32'hFFFF_BEEF, 1'b1, "R3");
    req(2'd1, 32'h0000_3000, 16'h0002, 32'h0000_CAFE, 1'b1, "R3");
    // R4: word
    req(2'd2, 32'h0000_4000, 16'h0004, 32'hDEAD_BEEF, 1'b1, "R4");
    // R5: misaligned accesses and reserved size
    req(2'd1, 32'h0000_3000, 16'h0001, 32'h0000_1111, 1'b1, "R5");
    req(2'd1, 32'h0000_3000, 16'h0003, 32'h0000_2222, 1'b1, "R5");
    req(2'd2, 32'h0000_4000, 16'h0002, 32'h3333_3333, 1'b1, "R5");
    req(2'd2, 32'h0000_4001, 16'h0000, 32'h4444_4444, 1'b0, "R5");
    req(2'd3, 32'h0000_4000, 16'h0000, 32'h5555_5555, 1'b1, "R5");
    // R5 then aligned: flag lasts one cycle
    req(2'd2, 32'h0000_4000, 16'h0008, 32'h0BAD_F00D, 1'b1, "R4");
    // R11: idle cycle
    req_valid = 1'b0; rsp_valid = 1'b0; tick("R11", "R11");

    // R6, R7: bytes from each lane
    for (int k = 0; k < 4; k++) ld(32'h807F_C312, 2'(k), 2'd0, 1'b0, "R6");
    for (int k = 0; k < 4; k++) ld(32'h807F_C312, 2'(k), 2'd0, 1'b1, "R7");
    // R8: halfwords, offset bit 0 ignored
    ld(32'h8001_7FFE, 2'd0, 2'd1, 1'b0, "R8");
    ld(32'h8001_7FFE, 2'd1, 2'd1, 1'b0, "R8");
    ld(32'h8001_7FFE, 2'd2, 2'd1, 1'b0, "R8");
    ld(32'h1234_F00F, 2'd3, 2'd1, 1'b0, "R8");
    ld(32'h8001_7FFE, 2'd0, 2'd1, 1'b1, "R7");
    ld(32'h1234_F00F, 2'd2, 2'd1, 1'b1, "R7");
    // R9: word passes through
    ld(32'hF00D_8080, 2'd0, 2'd2, 1'b0, "R9");
    ld(32'h8000_0001, 2'd3, 2'd3, 1'b1, "R9");

    // simultaneous request and load
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0;
    base_addr = 32'h0000_5000; req_offset = 16'h0002; req_wdata = 32'h0000_0077;
    rsp_valid = 1'b1; rsp_word = 32'h00FF_0000; rsp_lane = 2'd1; rsp_size = 2'd0; rsp_unsigned = 1'b0;
    tick("R2", "R6");

    req_valid = 1'b0; rsp_valid = 1'b0;
    tick("R11", "R11");
    tick("R11", "R11");
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule